// File: doc/BRIEF.md
# Dual-Bank Selectable Clock Divider

This block takes one fast source clock and produces two banks of divided clocks, each bank fanned out to a parameterised number of identical outputs (four by default). The source is picked from three incoming clocks. A path select chooses either an internal high-rate clock or the reference path. On the reference path, a second select picks one of two reference clocks. Each bank has its own 2-bit ratio code. The two banks give different ratio sets for the same code, and every ratio is even, so each output runs at a 50% duty cycle.

A single active-high control serves as both master reset and output disable. While it is high, every divider counter is cleared at once and all outputs of both banks float. When it falls, a short synchroniser on the selected source clock releases the counters on a clock edge. Both banks then start from the same point, and their first rising edges coincide. A ratio code changed while the block runs is taken up only when the current full output period ends, so no shortened pulse appears.

Top module: `dual_bank_clkdiv`

## Requirements
- R1: Bank A output period is 2, 4, 6 or 8 source cycles for ratio code 00, 01, 10 or 11 (code bit 1 is the MSB), high for exactly the first half of each period.
- R2: Bank B output period is 4, 6, 8 or 12 source cycles for ratio code 00, 01, 10 or 11, high for exactly the first half of each period.
- R3: All outputs of one bank carry the same value at all times while driven.
- R4: While `mr_oe` is 1, every output of both banks is high impedance and all divider counters are cleared, both taking effect without waiting for a clock edge.
- R5: After `mr_oe` falls, both banks are still low after the second source rising edge and both go high on the third source rising edge.
- R6: With `use_pll` = 1 the dividers count edges of `vco_clk`; with `use_pll` = 0 they count edges of the reference clock chosen by `ref_pick`.
- R7: With `use_pll` = 0, `ref_pick` = 0 selects `ref_clk0` and `ref_pick` = 1 selects `ref_clk1`; with `use_pll` = 1, `ref_pick` has no effect on the outputs.
- R8: A ratio code change is applied at the start of the next output period of that bank; the period in progress completes at its old length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vco_clk | input | 1 | Internal high-rate clock |
| ref_clk0 | input | 1 | Reference clock, choice 0 |
| ref_clk1 | input | 1 | Reference clock, choice 1 |
| use_pll | input | 1 | 1: count vco_clk, 0: count chosen reference |
| ref_pick | input | 1 | Reference choice, 0 or 1 |
| mr_oe | input | 1 | 1: clear counters and float all outputs |
| sel_a | input | 2 | Bank A ratio code |
| sel_b | input | 2 | Bank B ratio code |
| qa | output | OUTS_PER_BANK | Bank A divided clock outputs |
| qb | output | OUTS_PER_BANK | Bank B divided clock outputs |

## Verification
All sixteen pairs of ratio codes are run on the high-rate path and on each reference clock. The three clocks have distinct periods, so an output that counts the wrong source drifts away from the reference model within a few cycles. This separates R6 and R7 from the ratio decoding of R1 and R2. Every run starts by raising and then dropping `mr_oe`, which exercises floating outputs, the exact release edge and the alignment of the two banks. A separate run changes both codes part-way through a long period, so that early adoption of the new code shows up as a shortened high or low phase.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  typedef enum logic {
    BANK_FINE   = 1'b0,
    BANK_COARSE = 1'b1
  } bank_kind_e;

  localparam int unsigned SEL_W     = 2;
  localparam int unsigned MAX_RATIO = 12;
  localparam int unsigned CNT_W     = $clog2(MAX_RATIO);

  // Fine bank: 2,4,6,8.  Coarse bank: 4,6,8,12.
  function automatic logic [CNT_W-1:0] ratio_of(input bank_kind_e kind,
                                                input logic [SEL_W-1:0] code);
    logic [CNT_W-1:0] r;
    if (kind == BANK_FINE) begin
      r = CNT_W'(2 * (int'(code) + 1));
    end else if (code == 2'b11) begin
      r = CNT_W'(MAX_RATIO);
    end else begin
      r = CNT_W'(2 * (int'(code) + 2));
    end
    return r;
  endfunction

endpackage

// File: rtl/clkdiv_src_mux.sv
module clkdiv_src_mux (
  input  logic vco_clk,
  input  logic ref_clk0,
  input  logic ref_clk1,
  input  logic use_pll,
  input  logic ref_pick,
  output logic src_clk
);

  logic ref_clk;

  assign ref_clk = ref_pick ? ref_clk1 : ref_clk0;
  assign src_clk = use_pll ? vco_clk : ref_clk;

endmodule

// File: rtl/clkdiv_rst_sync.sv
module clkdiv_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
  import clkdiv_pkg::*;
#(
  parameter bank_kind_e KIND = BANK_FINE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  output logic             div_q
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] half_q, half_d;
  logic [CNT_W-1:0] ratio_sel;
  logic             out_q, out_d;
  logic             wrap;
  logic             cnt_en;

  assign cnt_en = 1'b1;

  always_comb begin
    ratio_sel = ratio_of(KIND, sel);
    wrap      = (cnt_q == '0);
    if (wrap) begin
      cnt_d  = ratio_sel - 1'b1;
      half_d = ratio_sel >> 1;
    end else begin
      cnt_d  = cnt_q - 1'b1;
      half_d = half_q;
    end
    out_d = (cnt_d >= half_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      half_q <= CNT_W'(1);
      out_q  <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      half_q <= half_d;
      out_q  <= out_d;
    end
  end

  assign div_q = out_q;

  AST_HIGH_AFTER_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) |=> out_q); // R1

  AST_LOW_AT_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_q) |-> (cnt_q == half_q - 1'b1)); // R2

  AST_RATIO_HOLDS_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |=> $stable(half_q)); // R8

endmodule

// File: rtl/dual_bank_clkdiv.sv
module dual_bank_clkdiv
  import clkdiv_pkg::*;
#(
  parameter int unsigned OUTS_PER_BANK = 4,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic                     vco_clk,
  input  logic                     ref_clk0,
  input  logic                     ref_clk1,
  input  logic                     use_pll,
  input  logic                     ref_pick,
  input  logic                     mr_oe,
  input  logic [SEL_W-1:0]         sel_a,
  input  logic [SEL_W-1:0]         sel_b,
  output logic [OUTS_PER_BANK-1:0] qa,
  output logic [OUTS_PER_BANK-1:0] qb
);

  logic src_clk;
  logic core_rst_n;
  logic div_a;
  logic div_b;

  clkdiv_src_mux u_mux (
    .vco_clk  (vco_clk),
    .ref_clk0 (ref_clk0),
    .ref_clk1 (ref_clk1),
    .use_pll  (use_pll),
    .ref_pick (ref_pick),
    .src_clk  (src_clk)
  );

  clkdiv_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (src_clk),
    .arst_n  (~mr_oe),
    .rst_n_o (core_rst_n)
  );

  clkdiv_bank #(.KIND(BANK_FINE)) u_bank_a (
    .clk   (src_clk),
    .rst_n (core_rst_n),
    .sel   (sel_a),
    .div_q (div_a)
  );

  clkdiv_bank #(.KIND(BANK_COARSE)) u_bank_b (
    .clk   (src_clk),
    .rst_n (core_rst_n),
    .sel   (sel_b),
    .div_q (div_b)
  );

  for (genvar i = 0; i < OUTS_PER_BANK; i++) begin : g_fanout
    assign qa[i] = mr_oe ? 1'bz : div_a;
    assign qb[i] = mr_oe ? 1'bz : div_b;
  end

  AST_BANKS_START_TOGETHER: assert property (@(posedge src_clk) disable iff (mr_oe)
    $rose(core_rst_n) |=> (div_a && div_b)); // R5

endmodule

// File: tb/dual_bank_clkdiv_tb.sv
`timescale 1ns/1ps
module dual_bank_clkdiv_tb_top;

  localparam int CLK_PERIOD = 4;
  localparam int REF0_PERIOD = 10;
  localparam int REF1_PERIOD = 14;

  logic vco_clk = 1'b0, ref_clk0 = 1'b0, ref_clk1 = 1'b0;
  logic use_pll, ref_pick, mr_oe;
  logic [1:0] sel_a, sel_b;
  wire  [3:0] qa_w, qb_w;

  int checks = 0;
  int errors = 0;
  bit checking = 1'b0;
  string ctx = "R4";

  always #(CLK_PERIOD/2)  vco_clk  = ~vco_clk;
  always #(REF0_PERIOD/2) ref_clk0 = ~ref_clk0;
  always #(REF1_PERIOD/2) ref_clk1 = ~ref_clk1;

  for (genvar i = 0; i < 4; i++) begin : g_pu
    pullup (qa_w[i]);
    pullup (qb_w[i]);
  end

  dual_bank_clkdiv dut_i (
    .vco_clk (vco_clk), .ref_clk0 (ref_clk0), .ref_clk1 (ref_clk1),
    .use_pll (use_pll), .ref_pick (ref_pick), .mr_oe (mr_oe),
    .sel_a (sel_a), .sel_b (sel_b), .qa (qa_w), .qb (qb_w)
  );

  // Source clock as the requirements define it (R6, R7).
  logic tb_src;
  assign tb_src = use_pll ? vco_clk : (ref_pick ? ref_clk1 : ref_clk0);

  function automatic int want_a(input logic [1:0] c);
    case (c) 2'd0: return 2; 2'd1: return 4; 2'd2: return 6; default: return 8; endcase
  endfunction
  function automatic int want_b(input logic [1:0] c);
    case (c) 2'd0: return 4; 2'd1: return 6; 2'd2: return 8; default: return 12; endcase
  endfunction

  // Behavioural reference: edges since release, remaining cycles, high length.
  int rel = 0, left_a = 0, left_b = 0, hi_a = 1, hi_b = 1;
  logic exp_a = 1'b0, exp_b = 1'b0;

  always @(posedge tb_src or posedge mr_oe) begin
    if (mr_oe) begin
      rel = 0; left_a = 0; left_b = 0; exp_a = 1'b0; exp_b = 1'b0;
    end else if (rel < 2) begin
      rel++;
    end else begin
      if (left_a == 0) begin left_a = want_a(sel_a) - 1; hi_a = want_a(sel_a) / 2; end
      else left_a--;
      if (left_b == 0) begin left_b = want_b(sel_b) - 1; hi_b = want_b(sel_b) / 2; end
      else left_b--;
      exp_a = (left_a >= hi_a);
      exp_b = (left_b >= hi_b);
    end
  end

  task automatic check4(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s [%s] actual=%b expected=%b at %0t", tag, ctx, act, exp, $time);
    end
  endtask

  always @(negedge tb_src) begin
    if (checking) begin
      if (mr_oe) begin
        check4("R4", qa_w, 4'hF);
        check4("R4", qb_w, 4'hF);
      end else begin
        check4("R1", qa_w, {4{exp_a}});
        check4("R2", qb_w, {4{exp_b}});
        check4("R3", {3'b0, (qa_w == 4'h0 || qa_w == 4'hF) && (qb_w == 4'h0 || qb_w == 4'hF)}, 4'h1);
      end
    end
  end

  task automatic run_combo(input logic pll, input logic rp, input logic [1:0] a,
                           input logic [1:0] b, input int cycles);
    @(negedge tb_src); #1;
    mr_oe = 1'b1;
    use_pll = pll; ref_pick = rp; sel_a = a; sel_b = b;
    #(3 * REF1_PERIOD);
    @(negedge tb_src); #1;
    mr_oe = 1'b0;
    @(posedge tb_src); @(posedge tb_src);
    @(negedge tb_src);
    check4("R5", {qa_w[0], qb_w[0], 2'b00}, 4'h0);
    @(posedge tb_src);
    @(negedge tb_src);
    check4("R5", {qa_w[0], qb_w[0], 2'b00}, 4'hC);
    repeat (cycles) @(negedge tb_src);
  endtask

  initial begin
    mr_oe = 1'b1; use_pll = 1'b1; ref_pick = 1'b0; sel_a = 2'b00; sel_b = 2'b00;
    #1 checking = 1'b1;
    #(4 * CLK_PERIOD);
    ctx = "R4 reset";
    check4("R4", qa_w, 4'hF);
    check4("R4", qb_w, 4'hF);

    // R6: high-rate path, with ref_pick toggled to show it is ignored (R7).
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++) begin
        ctx = "R6 vco";
        run_combo(1'b1, 1'(a ^ b), 2'(a), 2'(b), 30);
      end
    // R7: each reference clock in turn on the bypass path.
    for (int rp = 0; rp < 2; rp++)
      for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++) begin
          ctx = (rp == 0) ? "R7 ref0" : "R7 ref1";
          run_combo(1'b0, 1'(rp), 2'(a), 2'(b), 30);
        end

    // R8: change both codes in the middle of a long period.
    ctx = "R8 midperiod";
    run_combo(1'b1, 1'b0, 2'b11, 2'b11, 2);
    @(negedge tb_src); #1;
    sel_a = 2'b00; sel_b = 2'b01;
    repeat (40) @(negedge tb_src);
    @(negedge tb_src); #1;
    sel_a = 2'b10; sel_b = 2'b11;
    repeat (40) @(negedge tb_src);

    // R4: assert mr_oe mid-run.
    ctx = "R4 midrun";
    @(negedge tb_src); #1;
    mr_oe = 1'b1;
    repeat (4) @(negedge tb_src);

    checking = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule